// File: doc/BRIEF.md
# Multi-Channel APB Interval Timer

This block is an interval timer with a parameterised number of channels, each owning a reload value and a down-counter, programmed through an APB slave port. Software picks a counting width per channel and a tick source: either every bus clock, or rising edges of an asynchronous external tick line. A channel can run as one full-width timer, or be split into two half-width or four quarter-width sub-timers that share the channel's reload and counter registers lane by lane.

Every sub-timer has its own run bit and its own interrupt-enable and status bits. When an enabled sub-timer is at zero and a tick arrives, it reloads and raises its status bit. Software clears status bits by writing ones to them. A single interrupt line is raised while any status bit is set and also enabled. A full-width channel that free-runs from an all-ones reload can be read back inverted, which gives an up-counting timebase.

Top module: `itmr_apb_top`

## Requirements
- R1: After reset the identification register (0x00) reads ID_VALUE, the configuration register (0x10) reads NUM_CH, the interrupt-enable, status, run and every per-channel register read 0, and irq is low.
- R2: Shared registers are interrupt enable at 0x14, status at 0x18 and run at 0x1C. Channel c has control at 0x20+0x10*c, reload at 0x24+0x10*c and counter at 0x28+0x10*c. Sub-timer i of channel c owns bit 4*c+i of the enable, status and run registers.
- R3: Control bits [2:0] equal to 1 select full-width mode. Setting the run bit loads the counter from the reload value R. Each later tick decrements it. A tick at zero reloads R and sets status bit 4*c in the same cycle, so with the bus clock as the source the status bit sets R+1 cycles after the run write.
- R4: Control bits [2:0] equal to 2 split the channel into two 16-bit sub-timers. Sub-timer i uses counter and reload bits [16i+15:16i]. Each sub-timer counts, reloads and sets status bit 4*c+i independently of the other.
- R5: Control bits [2:0] equal to 3 split the channel into four 8-bit sub-timers. Sub-timer i uses bits [8i+7:8i] and status bit 4*c+i.
- R6: Control bit 3 selects the tick source. A value of 1 ticks on every clock. A value of 0 ticks once per rising edge of ext_tick, seen through a two-flop synchronizer, and the counter does not move while ext_tick is steady.
- R7: Clearing a run bit freezes that sub-timer's count. Setting it again restarts the sub-timer from the current reload value.
- R8: Writing the counter register loads the written value directly.
- R9: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A sub-timer expiry in the same cycle as a clearing write leaves the bit set.
- R10: irq is high exactly when some status bit and its interrupt-enable bit are both 1.
- R11: A full-width channel on the bus clock with reload 0xFFFFFFFF reads back, inverted, as the number of clocks elapsed since its run write. Channels count independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus clock, also the internal tick source |
| presetn | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| ext_tick | input | 1 | Asynchronous external tick line |
| irq | output | 1 | Combined interrupt request |

## Verification
A status bit can be set by a sub-timer expiry in the same clock edge that software's write-one clear arrives. The bench arms a bus-clock channel with a reload of 3 and waits a measured number of cycles, so that the access phase of the clearing write lands exactly on the expiry edge. It then stops the channel and expects the status bit to read back as 1. A clearing write that does not coincide with an expiry is checked separately and must read back 0, so a design where the clear takes priority fails one check and a design that ignores the clear fails the other.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  // Shared register byte offsets (software decodes these)
  localparam logic [7:0] OFS_ID   = 8'h00;
  localparam logic [7:0] OFS_CFG  = 8'h10;
  localparam logic [7:0] OFS_IEN  = 8'h14;
  localparam logic [7:0] OFS_STS  = 8'h18;
  localparam logic [7:0] OFS_RUN  = 8'h1C;

  // Channel block: base 0x20, stride 0x10, low nibble picks the register
  localparam int         CH_BASE_NIB = 2;
  localparam logic [3:0] SUB_CTL = 4'h0;
  localparam logic [3:0] SUB_RLD = 4'h4;
  localparam logic [3:0] SUB_CNT = 4'h8;

  // Bits per channel in the run / enable / status registers
  localparam int SUBS_PER_CH = 4;

  // Counting width selection in control bits [2:0]
  localparam logic [2:0] MODE_W32 = 3'd1;
  localparam logic [2:0] MODE_W16 = 3'd2;
  localparam logic [2:0] MODE_W8  = 3'd3;

  // Control bit 3: 1 = bus clock ticks, 0 = external tick edges
  localparam int CTL_SRC_BIT = 3;
  localparam int CTL_W       = 4;
endpackage

// File: rtl/itmr_rst_sync.sv
module itmr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/itmr_tick_sync.sv
module itmr_tick_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick_pulse
);
  // [0],[1]: synchronizer flops, [2]: edge-detect history
  logic [2:0] sh_q;
  logic [2:0] sh_d;

  always_comb begin
    sh_d = {sh_q[1:0], tick_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign tick_pulse = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/itmr_chan.sv
module itmr_chan
  import itmr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             mode,
  input  logic                   tick,
  input  logic [SUBS_PER_CH-1:0] run,
  input  logic [SUBS_PER_CH-1:0] start,
  input  logic [DW-1:0]          reload,
  input  logic                   load_wr,
  input  logic [DW-1:0]          load_val,
  output logic [DW-1:0]          count,
  output logic [SUBS_PER_CH-1:0] expire
);
  localparam int HW = DW / 2;
  localparam int QW = DW / 4;

  logic [DW-1:0]          cnt_q;
  logic [DW-1:0]          cnt_d;
  logic [SUBS_PER_CH-1:0] exp_d;

  always_comb begin
    cnt_d = cnt_q;
    exp_d = '0;
    case (mode)
      MODE_W32: begin
        if (start[0]) begin
          cnt_d = reload;
        end else if (run[0] && tick) begin
          if (cnt_q == '0) begin
            cnt_d    = reload;
            exp_d[0] = 1'b1;
          end else begin
            cnt_d = cnt_q - DW'(1);
          end
        end
      end
      MODE_W16: begin
        for (int i = 0; i < 2; i++) begin
          if (start[i]) begin
            cnt_d[i*HW +: HW] = reload[i*HW +: HW];
          end else if (run[i] && tick) begin
            if (cnt_q[i*HW +: HW] == '0) begin
              cnt_d[i*HW +: HW] = reload[i*HW +: HW];
              exp_d[i]          = 1'b1;
            end else begin
              cnt_d[i*HW +: HW] = cnt_q[i*HW +: HW] - HW'(1);
            end
          end
        end
      end
      MODE_W8: begin
        for (int i = 0; i < 4; i++) begin
          if (start[i]) begin
            cnt_d[i*QW +: QW] = reload[i*QW +: QW];
          end else if (run[i] && tick) begin
            if (cnt_q[i*QW +: QW] == '0) begin
              cnt_d[i*QW +: QW] = reload[i*QW +: QW];
              exp_d[i]          = 1'b1;
            end else begin
              cnt_d[i*QW +: QW] = cnt_q[i*QW +: QW] - QW'(1);
            end
          end
        end
      end
      default: begin
        cnt_d = cnt_q;
      end
    endcase
    if (load_wr) begin
      cnt_d = load_val;
      exp_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count  = cnt_q;
  assign expire = exp_d;
endmodule

// File: rtl/itmr_apb_top.sv
module itmr_apb_top
  import itmr_pkg::*;
#(
  parameter int          NUM_CH   = 2,
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h0001_0100
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              ext_tick,
  output logic              irq
);
  localparam int BITS  = SUBS_PER_CH * NUM_CH;
  localparam int HI_W  = ADDR_W - 4;

  logic rst_sync_n;
  logic ext_pulse;
  logic wr_acc;

  logic            ien_we, sts_we, run_we, sts_upd;
  logic [BITS-1:0] ien_q, ien_d;
  logic [BITS-1:0] sts_q, sts_d;
  logic [BITS-1:0] run_q, run_d;
  logic [BITS-1:0] start_all;
  logic [BITS-1:0] exp_all;

  logic [NUM_CH-1:0] ch_sel;
  logic [NUM_CH-1:0] ctl_we, rld_we, cnt_we;
  logic [CTL_W-1:0]  ctl_q [NUM_CH];
  logic [DATA_W-1:0] rld_q [NUM_CH];
  logic [DATA_W-1:0] ch_cnt [NUM_CH];

  itmr_rst_sync u_rst (
    .clk    (pclk),
    .arst_n (presetn),
    .srst_n (rst_sync_n)
  );

  itmr_tick_sync u_tick (
    .clk        (pclk),
    .rst_n      (rst_sync_n),
    .tick_in    (ext_tick),
    .tick_pulse (ext_pulse)
  );

  // Bus decode
  assign wr_acc = psel & penable & pwrite;
  assign ien_we = wr_acc && (paddr == ADDR_W'(OFS_IEN));
  assign sts_we = wr_acc && (paddr == ADDR_W'(OFS_STS));
  assign run_we = wr_acc && (paddr == ADDR_W'(OFS_RUN));

  // Shared register next state
  always_comb begin
    ien_d     = pwdata[BITS-1:0];
    run_d     = pwdata[BITS-1:0];
    start_all = run_we ? (pwdata[BITS-1:0] & ~run_q) : '0;
    sts_d     = (sts_q & ~(sts_we ? pwdata[BITS-1:0] : {BITS{1'b0}})) | exp_all;
    sts_upd   = sts_we | (|exp_all);
  end

  always_ff @(posedge pclk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ien_q <= '0;
      sts_q <= '0;
      run_q <= '0;
    end else begin
      if (ien_we)  ien_q <= ien_d;
      if (sts_upd) sts_q <= sts_d;
      if (run_we)  run_q <= run_d;
    end
  end

  // Per-channel registers and counters
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic tick_c;

    assign ch_sel[c] = (paddr[ADDR_W-1:4] == HI_W'(c + CH_BASE_NIB));
    assign ctl_we[c] = wr_acc && ch_sel[c] && (paddr[3:0] == SUB_CTL);
    assign rld_we[c] = wr_acc && ch_sel[c] && (paddr[3:0] == SUB_RLD);
    assign cnt_we[c] = wr_acc && ch_sel[c] && (paddr[3:0] == SUB_CNT);

    always_ff @(posedge pclk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        ctl_q[c] <= '0;
        rld_q[c] <= '0;
      end else begin
        if (ctl_we[c]) ctl_q[c] <= pwdata[CTL_W-1:0];
        if (rld_we[c]) rld_q[c] <= pwdata;
      end
    end

    assign tick_c = ctl_q[c][CTL_SRC_BIT] ? 1'b1 : ext_pulse;

    itmr_chan #(.DW(DATA_W)) u_chan (
      .clk      (pclk),
      .rst_n    (rst_sync_n),
      .mode     (ctl_q[c][2:0]),
      .tick     (tick_c),
      .run      (run_q[c*SUBS_PER_CH +: SUBS_PER_CH]),
      .start    (start_all[c*SUBS_PER_CH +: SUBS_PER_CH]),
      .reload   (rld_q[c]),
      .load_wr  (cnt_we[c]),
      .load_val (pwdata),
      .count    (ch_cnt[c]),
      .expire   (exp_all[c*SUBS_PER_CH +: SUBS_PER_CH])
    );
  end

  // Read mux
  always_comb begin
    prdata = '0;
    if (paddr == ADDR_W'(OFS_ID))  prdata = DATA_W'(ID_VALUE);
    if (paddr == ADDR_W'(OFS_CFG)) prdata = DATA_W'(NUM_CH);
    if (paddr == ADDR_W'(OFS_IEN)) prdata = DATA_W'(ien_q);
    if (paddr == ADDR_W'(OFS_STS)) prdata = DATA_W'(sts_q);
    if (paddr == ADDR_W'(OFS_RUN)) prdata = DATA_W'(run_q);
    for (int k = 0; k < NUM_CH; k++) begin
      if (ch_sel[k]) begin
        case (paddr[3:0])
          SUB_CTL: prdata = DATA_W'(ctl_q[k]);
          SUB_RLD: prdata = rld_q[k];
          SUB_CNT: prdata = ch_cnt[k];
          default: prdata = '0;
        endcase
      end
    end
  end

  assign irq = |(sts_q & ien_q);
endmodule

// File: rtl/itmr_apb_chk.sv
module itmr_apb_chk
  import itmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                     pclk,
  input logic                     rst_n,
  input logic                     psel,
  input logic                     penable,
  input logic                     pwrite,
  input logic [ADDR_W-1:0]        paddr,
  input logic [DATA_W-1:0]        pwdata,
  input logic [DATA_W-1:0]        prdata,
  input logic                     irq,
  input logic [4*NUM_CH-1:0]      ien_q,
  input logic [4*NUM_CH-1:0]      sts_q,
  input logic [4*NUM_CH-1:0]      run_q,
  input logic [4*NUM_CH-1:0]      exp_all,
  input logic                     ext_pulse,
  input logic [DATA_W-1:0]        cnt0
);
  logic wr_acc, sts_clr0, touch0;

  assign wr_acc   = psel & penable & pwrite;
  assign sts_clr0 = wr_acc && (paddr == ADDR_W'(OFS_STS)) && pwdata[0];
  assign touch0   = wr_acc && ((paddr == ADDR_W'(OFS_RUN)) ||
                               (paddr == ADDR_W'(8'h28)));

  AST_CFG_READBACK: assert property (@(posedge pclk) disable iff (!rst_n)
    (psel && !pwrite && paddr == ADDR_W'(OFS_CFG)) |-> prdata == DATA_W'(NUM_CH)); // R2

  AST_IRQ_MASKED: assert property (@(posedge pclk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq); // R10

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge pclk) disable iff (!rst_n)
    (sts_q == '0) |-> !irq); // R10

  AST_SET_BEATS_CLEAR: assert property (@(posedge pclk) disable iff (!rst_n)
    exp_all[0] |=> sts_q[0]); // R9

  AST_W1C_CLEARS: assert property (@(posedge pclk) disable iff (!rst_n)
    (sts_clr0 && !exp_all[0]) |=> !sts_q[0]); // R9

  AST_STATUS_HOLDS: assert property (@(posedge pclk) disable iff (!rst_n)
    (!exp_all[0] && !sts_clr0) |=> (sts_q[0] == $past(sts_q[0]))); // R9

  AST_STOPPED_FROZEN: assert property (@(posedge pclk) disable iff (!rst_n)
    (run_q[3:0] == 4'b0 && !touch0) |=> $stable(cnt0)); // R7

  AST_EXT_SINGLE_PULSE: assert property (@(posedge pclk) disable iff (!rst_n)
    ext_pulse |=> !ext_pulse); // R6
endmodule

bind itmr_apb_top itmr_apb_chk #(
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .pclk      (pclk),
  .rst_n     (rst_sync_n),
  .psel      (psel),
  .penable   (penable),
  .pwrite    (pwrite),
  .paddr     (paddr),
  .pwdata    (pwdata),
  .prdata    (prdata),
  .irq       (irq),
  .ien_q     (ien_q),
  .sts_q     (sts_q),
  .run_q     (run_q),
  .exp_all   (exp_all),
  .ext_pulse (ext_pulse),
  .cnt0      (ch_cnt[0])
);

// File: tb/itmr_apb_top_test.sv
module itmr_apb_top_test;
  localparam logic [31:0] ID_V = 32'h0001_0100;

  logic        pclk = 1'b0;
  logic        presetn;
  logic        psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        ext_tick;
  logic        irq;

  int n_run  = 0;
  int n_fail = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  itmr_apb_top #(.NUM_CH(2), .ADDR_W(8), .DATA_W(32), .ID_VALUE(ID_V)) uut (
    .pclk     (pclk),
    .presetn  (presetn),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .prdata   (prdata),
    .ext_tick (ext_tick),
    .irq      (irq)
  );

  always #10 pclk = ~pclk;   // 50 MHz

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pop the expected item when a read access phase is on the bus
  always @(negedge pclk) begin : mon
    item_t it;
    if (psel && penable && !pwrite) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "scoreboard-empty", prdata, 32'h0);
      end else begin
        it = sb_q.pop_front();
        check(prdata === it.exp, it.tag, prdata, it.exp);
      end
    end
  end

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(posedge pclk); #2;
    penable = 1'b1;
    @(posedge pclk); #2;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  // Driver: push the expectation, then run the read
  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(posedge pclk); #2;
    penable = 1'b1;
    @(posedge pclk); #2;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic wait_irq(output int cyc);
    cyc = 0;
    while (!irq && cyc < 100) begin
      @(posedge pclk); #2;
      cyc++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge pclk);
    #2;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge pclk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int cyc;
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    ext_tick = 1'b0; presetn = 1'b0;
    idle(4);
    presetn = 1'b1;
    idle(4);

    // R1 reset state
    check(irq == 1'b0, "R1 irq after reset", 32'(irq), 32'h0);
    rd_chk(8'h00, ID_V,  "R1 id");
    rd_chk(8'h10, 32'd2, "R1 cfg channel count");
    rd_chk(8'h14, 32'h0, "R1 ien");
    rd_chk(8'h18, 32'h0, "R1 status");
    rd_chk(8'h1C, 32'h0, "R1 run");
    rd_chk(8'h28, 32'h0, "R1 ch0 counter");
    rd_chk(8'h24, 32'h0, "R1 ch0 reload");

    // R8 direct counter load, R2 channel register placement
    apb_wr(8'h28, 32'h0000_1234);
    rd_chk(8'h28, 32'h0000_1234, "R8 counter write");
    apb_wr(8'h38, 32'h0000_00AB);
    rd_chk(8'h38, 32'h0000_00AB, "R2 ch1 counter at 0x38");
    rd_chk(8'h28, 32'h0000_1234, "R2 ch0 counter untouched");

    // R3 full width on bus clock: reload 5 -> status after 6 cycles
    apb_wr(8'h20, 32'h9);
    apb_wr(8'h24, 32'd5);
    apb_wr(8'h14, 32'h1);
    apb_wr(8'h1C, 32'h1);
    wait_irq(cyc);
    check(cyc == 6, "R3 expiry period R+1", 32'(cyc), 32'd6);

    // R7 stop freezes count (stop write lands two ticks after reload)
    apb_wr(8'h1C, 32'h0);
    rd_chk(8'h28, 32'd3, "R7 frozen count");
    idle(5);
    rd_chk(8'h28, 32'd3, "R7 still frozen");

    // R9 write-zero keeps, write-one clears
    rd_chk(8'h18, 32'h1, "R3 status bit 0 set");
    apb_wr(8'h18, 32'h0);
    rd_chk(8'h18, 32'h1, "R9 write 0 no effect");
    apb_wr(8'h18, 32'h1);
    rd_chk(8'h18, 32'h0, "R9 write 1 clears");
    check(irq == 1'b0, "R10 irq drops after clear", 32'(irq), 32'h0);

    // R7 restart from the new reload value
    apb_wr(8'h24, 32'd2);
    apb_wr(8'h1C, 32'h1);
    wait_irq(cyc);
    check(cyc == 3, "R7 restart from reload", 32'(cyc), 32'd3);
    apb_wr(8'h1C, 32'h0);

    // R10 masked status does not raise irq
    apb_wr(8'h14, 32'h0);
    #1;
    check(irq == 1'b0, "R10 masked irq", 32'(irq), 32'h0);
    rd_chk(8'h18, 32'h1, "R10 status kept while masked");
    apb_wr(8'h18, 32'hFF);

    // R6 external tick source
    apb_wr(8'h20, 32'h1);
    apb_wr(8'h24, 32'd100);
    apb_wr(8'h1C, 32'h1);
    idle(10);
    rd_chk(8'h28, 32'd100, "R6 no ticks without ext edges");
    for (int k = 0; k < 5; k++) begin
      ext_tick = 1'b1; idle(3);
      ext_tick = 1'b0; idle(3);
    end
    idle(4);
    rd_chk(8'h28, 32'd95, "R6 one tick per ext edge");
    apb_wr(8'h1C, 32'h0);

    // R4 16-bit split: lanes reload 1 and 3, stop two ticks later
    apb_wr(8'h20, 32'hA);
    apb_wr(8'h24, 32'h0003_0001);
    apb_wr(8'h1C, 32'h3);
    apb_wr(8'h1C, 32'h0);
    rd_chk(8'h18, 32'h1, "R4 only lower half expired");
    rd_chk(8'h28, 32'h0001_0001, "R4 independent halves");
    apb_wr(8'h18, 32'hFF);

    // R5 8-bit split: lanes reload 1,2,3,4
    apb_wr(8'h20, 32'hB);
    apb_wr(8'h24, 32'h0403_0201);
    apb_wr(8'h1C, 32'hF);
    apb_wr(8'h1C, 32'h0);
    rd_chk(8'h18, 32'h1, "R5 only byte 0 expired");
    rd_chk(8'h28, 32'h0201_0001, "R5 independent bytes");
    apb_wr(8'h18, 32'hFF);

    // R11 inverted timebase on channel 1
    apb_wr(8'h30, 32'h9);
    apb_wr(8'h34, 32'hFFFF_FFFF);
    apb_wr(8'h1C, 32'h10);
    rd_chk(8'h38, ~32'd1, "R11 timebase after 1 clock");
    rd_chk(8'h38, ~32'd3, "R11 timebase after 3 clocks");
    rd_chk(8'h18, 32'h0, "R11 ch1 no expiry");
    apb_wr(8'h1C, 32'h0);

    // R9 expiry coinciding with a clearing write: bit stays set
    apb_wr(8'h20, 32'h9);
    apb_wr(8'h24, 32'd3);
    apb_wr(8'h1C, 32'h1);
    idle(2);
    apb_wr(8'h18, 32'h1);
    apb_wr(8'h1C, 32'h0);
    rd_chk(8'h18, 32'h1, "R9 set wins over clear");
    apb_wr(8'h18, 32'h1);
    rd_chk(8'h18, 32'h0, "R9 clear when no expiry");

    idle(2);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule